// File: doc/BRIEF.md
# Serial UART with RS485 Driver-Enable Bracketing

This block is an 8N1 asynchronous serial port with RTS/CTS flow control and a driver-enable output for a half-duplex RS485 transceiver. Bytes to send arrive on a valid/ready stream. Received bytes leave on a second valid/ready stream, each tagged with a framing-error flag. A programmable integer divisor sets the rate of a 16x oversampling tick. Any rate from 300 baud to 3 Mbaud can be reached from a suitable system clock.

The driver-enable output goes high one bit-time before the start bit and drops one bit-time after the stop bit. A byte waiting when a stop bit ends is sent straight away, and the driver stays enabled across the gap. A small receive queue drives request-to-send from two watermarks. The active-low modem inputs (DSR, DCD, RI) are synchronised and reported active-high. A falling edge on RI produces a one-cycle wake pulse. DTR is a registered, active-low copy of a request input.

Stream rules. On the transmit side a byte is taken in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only when clear-to-send is asserted and the transmitter is either idle or ending a stop bit. On the receive side `rx_valid` stays high, and `rx_data`/`rx_ferr` stay stable, until the consumer raises `rx_ready`. A byte that arrives while the queue is full is dropped.

Top module: `uart485_top`

## Requirements
- R1: After reset, `txd` is 1, `tx_de` is 0, `rts_n` is 0, `rx_valid` is 0 and `ri_wake` is 0.
- R2: A transmitted frame is a 0 start bit, then 8 data bits least significant first, then a 1 stop bit. Each bit lasts 16*`baud_div` clocks.
- R3: `tx_de` rises one bit-time before the start bit and falls one bit-time after the stop bit ends. `txd` is 1 whenever `tx_de` is 0.
- R4: If a byte is presented by the end of a stop bit, its start bit follows at once and `tx_de` does not drop between the two frames.
- R5: While `cts_n` is 1, `tx_ready` stays 0, no frame begins and `tx_de` stays 0.
- R6: The receiver samples each bit at its middle and delivers the byte on `rx_data`. `rx_valid`, `rx_data` and `rx_ferr` hold steady until `rx_ready` pops them, in arrival order.
- R7: A low pulse on `rxd` that is high again at mid start-bit (a low shorter than half a bit) produces no byte.
- R8: A stop bit sampled as 0 sets `rx_ferr` to 1 for that byte. The receiver then waits for the line to return high before it looks for the next start bit.
- R9: `rts_n` goes to 1 once the queue holds at least HI bytes (default 6). It returns to 0 only when the queue holds fewer than LO bytes (default 2).
- R10: `dsr_act`, `dcd_act` and `ri_act` are the inverted, synchronised `dsr_n`, `dcd_n` and `ri_n`. `dtr_n` is the inverse of `dtr_req`.
- R11: Each falling edge of `ri_n` gives exactly one single-cycle `ri_wake` pulse, however long `ri_n` stays low.
- R12: `tx_data` is captured on the handshake, and `tx_ready` is 0 during the start and data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIVW | Clocks per oversampling tick (0 treated as 1) |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmitter accepts byte |
| tx_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial transmit line |
| tx_de | output | 1 | Line driver enable |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer pops received byte |
| rx_data | output | 8 | Received byte |
| rx_ferr | output | 1 | Framing error on this byte |
| dtr_req | input | 1 | Request to assert DTR |
| dtr_n | output | 1 | Data terminal ready, active low |
| dsr_n | input | 1 | Data set ready, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dsr_act | output | 1 | DSR asserted |
| dcd_act | output | 1 | DCD asserted |
| ri_act | output | 1 | RI asserted |
| ri_wake | output | 1 | One-cycle wake pulse on RI assertion |

## Verification
The hardest situation to reach is the release of request-to-send. The queue has to be filled past the high mark with the consumer stalled, then drained one byte at a time, and `rts_n` must stay high until the level passes below the low mark. The bench holds `rx_ready` low across six serial frames, then pops single bytes and checks the flag at each level. The back-to-back handoff is also narrow: a byte must already be waiting in the one tick that ends a stop bit. The bench keeps `tx_valid` high from the first handshake onward, so that cycle is always covered.

// File: rtl/uart485_pkg.sv
package uart485_pkg;
  localparam int BYTE_W = 8;
  localparam int OVS    = 16;

  typedef enum logic [2:0] {
    TX_IDLE, TX_LEAD, TX_START, TX_DATA, TX_STOP, TX_LAG
  } tx_st_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_st_t;

  typedef struct packed {
    logic              ferr;
    logic [BYTE_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/uart485_sync.sv
module uart485_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/uart485_tx.sv
module uart485_tx
  import uart485_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cts_ok,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              txd,
  output logic              de
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(BYTE_W);

  tx_st_t            st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [BYTE_W-1:0] sh;
  logic              bit_end;
  logic              open_slot;
  logic              take;

  assign bit_end   = tick && (cnt == CW'(OVS - 1));
  assign open_slot = (st == TX_IDLE) || ((st == TX_STOP) && bit_end);
  assign tx_ready  = cts_ok && open_slot;
  assign take      = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
    end else begin
      if (tick) cnt <= cnt + CW'(1);
      unique case (st)
        TX_IDLE: if (take) begin
          sh  <= tx_data;
          cnt <= '0;
          st  <= TX_LEAD;
        end
        TX_LEAD:  if (bit_end) st <= TX_START;
        TX_START: if (bit_end) begin
          st   <= TX_DATA;
          bitn <= '0;
        end
        TX_DATA: if (bit_end) begin
          sh   <= {1'b0, sh[BYTE_W-1:1]};
          bitn <= bitn + BW'(1);
          if (bitn == BW'(BYTE_W - 1)) st <= TX_STOP;
        end
        TX_STOP: if (bit_end) begin
          if (take) begin
            sh <= tx_data;
            st <= TX_START;
          end else begin
            st <= TX_LAG;
          end
        end
        TX_LAG:  if (bit_end) st <= TX_IDLE;
        default: st <= TX_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      TX_START: txd = 1'b0;
      TX_DATA:  txd = sh[0];
      default:  txd = 1'b1;
    endcase
  end

  assign de = (st != TX_IDLE);
endmodule

// File: rtl/uart485_rx.sv
module uart485_rx
  import uart485_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     rxs,
  output logic     push,
  output rx_word_t word
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(BYTE_W);

  rx_st_t            st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      unique case (st)
        RX_IDLE: if (tick && !rxs) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (tick) begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(OVS / 2 - 1)) begin
            if (!rxs) begin
              st   <= RX_DATA;
              cnt  <= '0;
              bitn <= '0;
            end else begin
              st <= RX_IDLE;
            end
          end
        end
        RX_DATA: if (tick) begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(OVS - 1)) begin
            sh   <= {rxs, sh[BYTE_W-1:1]};
            bitn <= bitn + BW'(1);
            if (bitn == BW'(BYTE_W - 1)) st <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(OVS - 1)) begin
            push      <= 1'b1;
            word.ferr <= !rxs;
            word.data <= sh;
            st        <= rxs ? RX_IDLE : RX_HOLD;
          end
        end
        RX_HOLD: if (rxs) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart485_rxq.sv
module uart485_rxq
  import uart485_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int HI    = 6,
  parameter int LO    = 2,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_word_t      in_word,
  input  logic          pop,
  output logic          out_valid,
  output rx_word_t      out_word,
  output logic [LW-1:0] level,
  output logic          rts_n
);
  localparam int AW = $clog2(DEPTH);

  rx_word_t      mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push   = push && (level != LW'(DEPTH));
  assign do_pop    = pop && (level != '0);
  assign out_valid = (level != '0);
  assign out_word  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= in_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
      rts_n <= 1'b0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      unique case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (level >= LW'(HI))     rts_n <= 1'b1;
      else if (level < LW'(LO)) rts_n <= 1'b0;
    end
  end
endmodule

// File: rtl/uart485_top.sv
module uart485_top
  import uart485_pkg::*;
#(
  parameter int DIVW      = 16,
  parameter int RXQ_DEPTH = 8,
  parameter int RXQ_HI    = 6,
  parameter int RXQ_LO    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIVW-1:0]   baud_div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              txd,
  output logic              tx_de,
  input  logic              cts_n,
  output logic              rts_n,
  input  logic              rxd,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_ferr,
  input  logic              dtr_req,
  output logic              dtr_n,
  input  logic              dsr_n,
  input  logic              dcd_n,
  input  logic              ri_n,
  output logic              dsr_act,
  output logic              dcd_act,
  output logic              ri_act,
  output logic              ri_wake
);
  localparam int LW = $clog2(RXQ_DEPTH) + 1;

  logic [DIVW-1:0] divcnt, div_last;
  logic            tick;

  assign div_last = (baud_div == '0) ? '0 : baud_div - DIVW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divcnt <= '0;
      tick   <= 1'b0;
    end else begin
      tick   <= (divcnt >= div_last);
      divcnt <= (divcnt >= div_last) ? '0 : divcnt + DIVW'(1);
    end
  end

  logic [4:0] raw_in, syn;
  assign raw_in = {ri_n, dcd_n, dsr_n, cts_n, rxd};

  uart485_sync #(.W(5)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  logic rxs, cts_ok, ri_prev;
  assign rxs    = syn[0];
  assign cts_ok = !syn[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtr_n   <= 1'b1;
      dsr_act <= 1'b0;
      dcd_act <= 1'b0;
      ri_act  <= 1'b0;
      ri_prev <= 1'b1;
      ri_wake <= 1'b0;
    end else begin
      dtr_n   <= !dtr_req;
      dsr_act <= !syn[2];
      dcd_act <= !syn[3];
      ri_act  <= !syn[4];
      ri_prev <= syn[4];
      ri_wake <= ri_prev && !syn[4];
    end
  end

  uart485_tx tx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cts_ok(cts_ok),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .txd(txd), .de(tx_de)
  );

  logic     rx_push;
  rx_word_t rx_in, rx_out;
  logic [LW-1:0] rxq_level;

  uart485_rx rx_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs),
    .push(rx_push), .word(rx_in)
  );

  uart485_rxq #(.DEPTH(RXQ_DEPTH), .HI(RXQ_HI), .LO(RXQ_LO), .LW(LW)) rxq_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .in_word(rx_in),
    .pop(rx_ready), .out_valid(rx_valid), .out_word(rx_out),
    .level(rxq_level), .rts_n(rts_n)
  );

  assign rx_data = rx_out.data;
  assign rx_ferr = rx_out.ferr;
endmodule

// File: rtl/uart485_chk.sv
module uart485_chk #(
  parameter int DEPTH = 8,
  parameter int HI    = 6,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          tx_de,
  input logic          rts_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [7:0]    rx_data,
  input logic          rx_ferr,
  input logic          ri_wake,
  input logic [LW-1:0] rx_level
);
  AST_LINE_MARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_de |-> txd); // R3
  AST_LEAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_de) |-> txd); // R3
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_ferr))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH)); // R9
  AST_RTS_HIGH_WATER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= LW'(HI)) |=> rts_n); // R9
  AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ri_wake |=> !ri_wake); // R11
endmodule

bind uart485_top uart485_chk #(.DEPTH(RXQ_DEPTH), .HI(RXQ_HI), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_de(tx_de), .rts_n(rts_n),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_ferr(rx_ferr), .ri_wake(ri_wake), .rx_level(rxq_level)
);

// File: tb/uart485_top_tb_top.sv
module uart485_top_tb_top;
  localparam int DIV = 2;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] baud_div = 16'(DIV);
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic txd, tx_de;
  logic cts_n = 1'b0, rts_n;
  logic rxd = 1'b1;
  logic rx_valid, rx_ready = 1'b0, rx_ferr;
  logic [7:0] rx_data;
  logic dtr_req = 1'b0, dtr_n;
  logic dsr_n = 1'b1, dcd_n = 1'b1, ri_n = 1'b1;
  logic dsr_act, dcd_act, ri_act, ri_wake;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart485_top dut_i (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .txd(txd), .tx_de(tx_de), .cts_n(cts_n), .rts_n(rts_n),
    .rxd(rxd), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .dtr_req(dtr_req),
    .dtr_n(dtr_n), .dsr_n(dsr_n), .dcd_n(dcd_n), .ri_n(ri_n),
    .dsr_act(dsr_act), .dcd_act(dcd_act), .ri_act(ri_act), .ri_wake(ri_wake)
  );

  // stop bit in [8], byte in [7:0]; expected rx_ferr = ~stop
  localparam logic [8:0] VEC [4] = '{9'h155, 9'h1A3, 9'h100, 9'h0FF};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_drive(input logic [7:0] b, input logic stop);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic rx_pop();
    rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic tx_frame(input logic [7:0] b);
    int hs, st, fall;
    logic [7:0] got;
    tx_data = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk); #1 hs = cyc;
    @(negedge clk) tx_valid = 1'b0;
    tx_data = 8'h00;
    while (txd) @(negedge clk);
    st = cyc;
    chk((st - hs) >= BIT - 2 && (st - hs) <= BIT + 2, "R3 lead", st - hs, BIT);
    repeat (16) @(negedge clk);
    chk(txd == 1'b0, "R2 start", txd, 0);
    chk(tx_ready == 1'b0, "R12 busy", tx_ready, 0);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      got[i] = txd;
    end
    chk(got == b, "R2 payload", got, b);
    repeat (BIT) @(negedge clk);
    chk(txd == 1'b1, "R2 stop", txd, 1);
    while (tx_de) @(negedge clk);
    fall = cyc;
    chk((fall - st) >= 11 * BIT - 3 && (fall - st) <= 11 * BIT + 3, "R3 lag",
        fall - st, 11 * BIT);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tx_de == 1'b0, "R1 de", tx_de, 0);
    chk(rts_n == 1'b0, "R1 rts", rts_n, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(ri_wake == 1'b0, "R1 wake", ri_wake, 0);

    // vector walk: receive path and transmit path
    for (int v = 0; v < 4; v++) begin
      rx_drive(VEC[v][7:0], VEC[v][8]);
      chk(rx_valid == 1'b1, "R6 valid", rx_valid, 1);
      chk(rx_data == VEC[v][7:0], "R6 data", rx_data, VEC[v][7:0]);
      chk(rx_ferr == !VEC[v][8], "R8 ferr", rx_ferr, !VEC[v][8]);
      repeat (3) @(negedge clk);
      chk(rx_valid == 1'b1 && rx_data == VEC[v][7:0], "R6 hold", rx_data, VEC[v][7:0]);
      rx_pop();
      chk(rx_valid == 1'b0, "R6 pop", rx_valid, 0);
      tx_frame(VEC[v][7:0]);
    end

    // R7 glitch rejection then a real frame
    rxd = 1'b0;
    repeat (BIT / 4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    chk(rx_valid == 1'b0, "R7 glitch", rx_valid, 0);
    rx_drive(8'h5A, 1'b1);
    chk(rx_valid && rx_data == 8'h5A, "R7 after glitch", rx_data, 8'h5A);
    rx_pop();

    // R5 CTS blocks transmit
    cts_n = 1'b1;
    repeat (8) @(negedge clk);
    tx_data = 8'h81;
    tx_valid = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (tx_de || tx_ready || !txd) seen = 1;
      end
      chk(!seen, "R5 cts hold", seen, 0);
    end
    cts_n = 1'b0;
    tx_valid = 1'b0;
    repeat (4) @(negedge clk);
    tx_frame(8'h81);

    // R4 back-to-back
    begin
      int hs2, st2;
      bit low_seen = 0;
      tx_data = 8'h3C;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk) tx_data = 8'hC3;
      while (!tx_ready) begin
        if (!tx_de) low_seen = 1;
        @(negedge clk);
      end
      @(posedge clk); #1 hs2 = cyc;
      @(negedge clk) tx_valid = 1'b0;
      while (txd) begin
        if (!tx_de) low_seen = 1;
        @(negedge clk);
      end
      st2 = cyc;
      chk(!low_seen, "R4 de held", low_seen, 0);
      chk((st2 - hs2) <= 2, "R4 no lead", st2 - hs2, 1);
      while (tx_de) @(negedge clk);
    end

    // R9 watermarks
    for (int k = 0; k < 5; k++) rx_drive(8'(8'h10 + k), 1'b1);
    chk(rts_n == 1'b0, "R9 below hi", rts_n, 0);
    rx_drive(8'h15, 1'b1);
    repeat (2) @(negedge clk);
    chk(rts_n == 1'b1, "R9 at hi", rts_n, 1);
    for (int k = 0; k < 4; k++) begin
      chk(rx_data == 8'(8'h10 + k), "R6 order", rx_data, 8'h10 + k);
      rx_pop();
    end
    repeat (2) @(negedge clk);
    chk(rts_n == 1'b1, "R9 at lo", rts_n, 1);
    rx_pop();
    repeat (2) @(negedge clk);
    chk(rts_n == 1'b0, "R9 below lo", rts_n, 0);
    rx_pop();
    chk(rx_valid == 1'b0, "R9 drained", rx_valid, 0);

    // R10 modem lines
    dsr_n = 1'b0; dcd_n = 1'b1; dtr_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(dsr_act == 1'b1 && dcd_act == 1'b0, "R10 dsr/dcd", {dsr_act, dcd_act}, 2);
    chk(dtr_n == 1'b0, "R10 dtr", dtr_n, 0);
    dcd_n = 1'b0; dtr_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(dcd_act == 1'b1 && dtr_n == 1'b1, "R10 dcd/dtr", {dcd_act, dtr_n}, 3);

    // R11 ring wake
    begin
      int pulses = 0;
      ri_n = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (ri_wake) pulses++;
      end
      chk(pulses == 1, "R11 wake", pulses, 1);
      chk(ri_act == 1'b1, "R10 ri", ri_act, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule